// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog for a processor subsystem. A counter runs up from zero while the watchdog is enabled. When it reaches a programmable threshold, the block drives a system reset request for a fixed number of cycles. Firmware prevents that by reloading the counter in time.

Every action that changes the watchdog's state passes through a key register. Software first writes an attention code and then writes a command code. The commands start, stop, reload or lock the watchdog, or grant the right to make one configuration write. After a lock, the watchdog can no longer be stopped and no new write rights are granted until the next reset.

A control bit lets the counter freeze while the core is halted for debug. All registers sit on a simple word-wide register bus. Reads are combinational from the address.

Top module: `wdt_top`

## Requirements
- R1: After reset, control, status and count read 0, the threshold reads THRESH_RST (default 1000) and sys_rst_o is low.
- R2: Writing 0xA5 to the key register (offset 0x30) sets status bit 0. A further 0xA5 keeps it set. The next key write with a command code executes that command and clears bit 0.
- R3: A key write that is not 0xA5 and is not preceded by an attention key is discarded, and status bit 0 reads 0 afterwards.
- R4: Command 0xEE starts the watchdog (status bit 2) and clears the count (offset 0x24). The count then rises by one per cycle. Command 0xDD stops it, and the count holds its value.
- R5: Command 0xCC reloads the count to 0.
- R6: While the watchdog runs and the count equals the threshold (offset 0x20), the next edge returns the count to 0 and raises sys_rst_o for exactly RST_CYCLES (default 8) cycles.
- R7: A reload or start command applied on the edge where the count equals the threshold takes priority. No reset pulse is produced and the count becomes 0.
- R8: Command 0xF1 grants a write privilege (status bit 1). Writes to the control aliases or the threshold are ignored without it. The first such write uses it up.
- R9: The control register has a direct alias at 0x00, a set alias at 0x04 and a clear alias at 0x08. Only bit 1 (debug freeze) is implemented, and the other bits read 0.
- R10: With control bit 1 set and dbg_halt_i high, the count holds.
- R11: Command 0xFF locks the watchdog (status bit 3) and drops any pending privilege. Until reset, 0xDD and 0xF1 are ignored, while 0xCC and 0xEE still act.
- R12: Status reads at 0x10, 0x14 and 0x18. A write to 0x18 clears bit 0 and/or bit 1 where the data has ones. Writes to 0x10 and 0x14 are ignored.
- R13: The key register and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| dbg_halt_i | input | 1 | Core halted for debug |
| sys_rst_o | output | 1 | System reset request |

## Verification
The reload command and the expiry of the counter can land on the same clock edge. The bench provokes this by starting the watchdog and counting idle cycles. It then places the attention and reload key writes so that the reload takes effect exactly on the edge where the count equals the threshold. The collision is judged correct if sys_rst_o stays low and the count reads 0 right after that edge. A run without the reload, using the same timing, must show the reset pulse. A randomized phase then cross-checks the key sequencing, privilege use and lock against a bench model of the status and control registers.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] KEY_ATTN   = 8'hA5;
  localparam logic [7:0] KEY_PERMIT = 8'hF1;
  localparam logic [7:0] KEY_KICK   = 8'hCC;
  localparam logic [7:0] KEY_HALT   = 8'hDD;
  localparam logic [7:0] KEY_GO     = 8'hEE;
  localparam logic [7:0] KEY_SEAL   = 8'hFF;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h10;
  localparam logic [7:0] OFS_THR  = 8'h20;
  localparam logic [7:0] OFS_CNT  = 8'h24;
  localparam logic [7:0] OFS_KEY  = 8'h30;
  localparam logic [7:0] OFS_SET  = 8'h04;
  localparam logic [7:0] OFS_CLR  = 8'h08;

  localparam logic [31:0] CTRL_MASK = 32'h0000_0002;
  localparam int CTRL_FREEZE_BIT = 1;

  localparam int ST_ATTN = 0;
  localparam int ST_PRIV = 1;
  localparam int ST_RUN  = 2;
  localparam int ST_LOCK = 3;

  typedef enum logic [1:0] {WR_NONE, WR_DIRECT, WR_SET, WR_CLEAR} wr_kind_e;
  typedef enum logic [2:0] {RD_ZERO, RD_CTRL, RD_STAT, RD_THR, RD_CNT} rd_sel_e;

  typedef struct packed {
    logic permit;
    logic kick;
    logic halt;
    logic go;
    logic seal;
  } key_cmd_t;
endpackage

// File: rtl/wdt_bus_dec.sv
module wdt_bus_dec
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wr_kind_e          ctrl_kind_o,
  output wr_kind_e          stat_kind_o,
  output logic              thr_wr_o,
  output logic              key_wr_o,
  output rd_sel_e           rd_sel_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_THR  = ADDR_W'(OFS_THR);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_CNT);
  localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(OFS_KEY);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);

  function automatic wr_kind_e kind_of(logic [ADDR_W-1:0] a, logic [ADDR_W-1:0] base);
    if (a == base)               return WR_DIRECT;
    else if (a == (base | A_SET)) return WR_SET;
    else if (a == (base | A_CLR)) return WR_CLEAR;
    else                          return WR_NONE;
  endfunction

  logic wr;
  wr_kind_e ctrl_hit, stat_hit;

  assign wr       = req_i & we_i;
  assign ctrl_hit = kind_of(addr_i, A_CTRL);
  assign stat_hit = kind_of(addr_i, A_STAT);

  assign ctrl_kind_o = wr ? ctrl_hit : WR_NONE;
  assign stat_kind_o = wr ? stat_hit : WR_NONE;
  assign thr_wr_o    = wr && (addr_i == A_THR);
  assign key_wr_o    = wr && (addr_i == A_KEY);

  always_comb begin
    if (ctrl_hit != WR_NONE)      rd_sel_o = RD_CTRL;
    else if (stat_hit != WR_NONE) rd_sel_o = RD_STAT;
    else if (addr_i == A_THR)     rd_sel_o = RD_THR;
    else if (addr_i == A_CNT)     rd_sel_o = RD_CNT;
    else                          rd_sel_o = RD_ZERO;
  end
endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       key_wr_i,
  input  logic [7:0] key_i,
  input  logic       attn_clr_i,
  output logic       attn_o,
  output key_cmd_t   cmd_o
);
  logic attn_q;
  logic armed;

  assign armed  = key_wr_i & attn_q;
  assign attn_o = attn_q;

  always_comb begin
    cmd_o = '0;
    if (armed) begin
      unique case (key_i)
        KEY_PERMIT: cmd_o.permit = 1'b1;
        KEY_KICK:   cmd_o.kick   = 1'b1;
        KEY_HALT:   cmd_o.halt   = 1'b1;
        KEY_GO:     cmd_o.go     = 1'b1;
        KEY_SEAL:   cmd_o.seal   = 1'b1;
        default:    cmd_o        = '0;
      endcase
    end
  end

  // any key write re-arms only on the attention code
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         attn_q <= 1'b0;
    else if (key_wr_i)   attn_q <= (key_i == KEY_ATTN);
    else if (attn_clr_i) attn_q <= 1'b0;
  end
endmodule

// File: rtl/wdt_ctrl_state.sv
module wdt_ctrl_state
  import wdt_pkg::*;
#(
  parameter int          CNT_W      = 16,
  parameter logic [31:0] THRESH_RST = 32'd1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  key_cmd_t         cmd_i,
  input  wr_kind_e         ctrl_kind_i,
  input  logic             thr_wr_i,
  input  logic             priv_clr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      ctrl_o,
  output logic [CNT_W-1:0] thresh_o,
  output logic             run_o,
  output logic             lock_o,
  output logic             wpriv_o
);
  logic [31:0]      ctrl_q;
  logic [CNT_W-1:0] thr_q;
  logic             run_q, lock_q, wpriv_q;
  logic             cfg_wr, gated;
  logic [31:0]      wmask;

  assign cfg_wr = (ctrl_kind_i != WR_NONE) | thr_wr_i;
  assign gated  = wpriv_q & cfg_wr;
  assign wmask  = wdata_i & CTRL_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      thr_q  <= CNT_W'(THRESH_RST);
    end else if (gated) begin
      unique case (ctrl_kind_i)
        WR_DIRECT: ctrl_q <= wmask;
        WR_SET:    ctrl_q <= ctrl_q | wmask;
        WR_CLEAR:  ctrl_q <= ctrl_q & ~wmask;
        default:   ctrl_q <= ctrl_q;
      endcase
      if (thr_wr_i) thr_q <= wdata_i[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      lock_q  <= 1'b0;
      wpriv_q <= 1'b0;
    end else begin
      if (cmd_i.go)                   run_q <= 1'b1;
      else if (cmd_i.halt && !lock_q) run_q <= 1'b0;

      if (cmd_i.seal) lock_q <= 1'b1;

      if (cmd_i.seal)                   wpriv_q <= 1'b0;
      else if (cmd_i.permit && !lock_q) wpriv_q <= 1'b1;
      else if (gated || priv_clr_i)     wpriv_q <= 1'b0;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign thresh_o = thr_q;
  assign run_o    = run_q;
  assign lock_o   = lock_q;
  assign wpriv_o  = wpriv_q;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W      = 16,
  parameter int RST_CYCLES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             hold_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sys_rst_o
);
  localparam int RW = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [RW-1:0]    pulse_q;
  logic             tick, expire;

  assign tick   = run_i & ~hold_i;
  // restart wins over a coincident expiry
  assign expire = tick & ~restart_i & (cnt_q == thresh_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (expire)    cnt_q <= '0;
    else if (tick)      cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pulse_q <= '0;
    else if (expire)          pulse_q <= RW'(RST_CYCLES);
    else if (pulse_q != '0)   pulse_q <= pulse_q - 1'b1;
  end

  assign cnt_o     = cnt_q;
  assign sys_rst_o = (pulse_q != '0);
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int          ADDR_W     = 6,
  parameter int          CNT_W      = 16,
  parameter int          RST_CYCLES = 8,
  parameter logic [31:0] THRESH_RST = 32'd1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              dbg_halt_i,
  output logic              sys_rst_o
);
  wr_kind_e         ctrl_kind, stat_kind;
  rd_sel_e          rd_sel;
  logic             thr_wr, key_wr;
  key_cmd_t         cmd;
  logic             attn, run, lock, wpriv, hold, restart, cfg_wr;
  logic             attn_clr, priv_clr;
  logic [31:0]      ctrl;
  logic [CNT_W-1:0] thresh, cnt;
  logic [31:0]      status;

  wdt_bus_dec #(.ADDR_W(ADDR_W)) dec_i (
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .ctrl_kind_o(ctrl_kind), .stat_kind_o(stat_kind),
    .thr_wr_o(thr_wr), .key_wr_o(key_wr), .rd_sel_o(rd_sel)
  );

  // only the clear alias of status has an effect
  assign attn_clr = (stat_kind == WR_CLEAR) & wdata_i[ST_ATTN];
  assign priv_clr = (stat_kind == WR_CLEAR) & wdata_i[ST_PRIV];

  wdt_key_seq key_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .key_wr_i(key_wr), .key_i(wdata_i[7:0]),
    .attn_clr_i(attn_clr), .attn_o(attn), .cmd_o(cmd)
  );

  wdt_ctrl_state #(.CNT_W(CNT_W), .THRESH_RST(THRESH_RST)) state_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd), .ctrl_kind_i(ctrl_kind),
    .thr_wr_i(thr_wr), .priv_clr_i(priv_clr), .wdata_i(wdata_i),
    .ctrl_o(ctrl), .thresh_o(thresh), .run_o(run), .lock_o(lock), .wpriv_o(wpriv)
  );

  assign hold    = ctrl[CTRL_FREEZE_BIT] & dbg_halt_i;
  assign restart = cmd.go | cmd.kick;
  assign cfg_wr  = (ctrl_kind != WR_NONE) | thr_wr;

  wdt_counter #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) cnt_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .hold_i(hold),
    .restart_i(restart), .thresh_i(thresh), .cnt_o(cnt), .sys_rst_o(sys_rst_o)
  );

  always_comb begin
    status = '0;
    status[ST_ATTN] = attn;
    status[ST_PRIV] = wpriv;
    status[ST_RUN]  = run;
    status[ST_LOCK] = lock;
  end

  always_comb begin
    unique case (rd_sel)
      RD_CTRL: rdata_o = ctrl;
      RD_STAT: rdata_o = status;
      RD_THR:  rdata_o = 32'(thresh);
      RD_CNT:  rdata_o = 32'(cnt);
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             hold_i,
  input logic             restart_i,
  input logic             lock_i,
  input logic             wpriv_i,
  input logic             cfg_wr_i,
  input logic             key_wr_i,
  input logic [7:0]       key_i,
  input logic             attn_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] thresh_i,
  input logic             sys_rst_i
);
  assert_attn_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_wr_i && key_i == KEY_ATTN |=> attn_i);

  assert_stray_key_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_wr_i && !attn_i && key_i != KEY_ATTN |=> !attn_i);

  assert_count_up_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !hold_i && !restart_i && cnt_i != thresh_i |=> cnt_i == CNT_W'($past(cnt_i) + 1'b1));

  assert_reset_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_i) |-> $past(run_i && !hold_i && !restart_i && cnt_i == thresh_i));

  assert_restart_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> cnt_i == '0 && !$rose(sys_rst_i));

  assert_priv_used_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wpriv_i && cfg_wr_i |=> !wpriv_i);

  assert_freeze_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && hold_i && !restart_i |=> $stable(cnt_i));

  assert_lock_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> lock_i);

  assert_lock_run_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i && run_i |=> run_i);
endmodule

bind wdt_top wdt_checker #(.CNT_W(CNT_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .hold_i(hold), .restart_i(restart),
  .lock_i(lock), .wpriv_i(wpriv), .cfg_wr_i(cfg_wr), .key_wr_i(key_wr),
  .key_i(wdata_i[7:0]), .attn_i(attn), .cnt_i(cnt), .thresh_i(thresh),
  .sys_rst_i(sys_rst_o)
);

// File: tb/wdt_top_tb_top.sv
`timescale 1ns/1ps
module wdt_top_tb_top;
  localparam int RSTC = 8;
  localparam logic [5:0] A_CTRL = 6'h00, A_CSET = 6'h04, A_CCLR = 6'h08;
  localparam logic [5:0] A_STAT = 6'h10, A_SSET = 6'h14, A_SCLR = 6'h18;
  localparam logic [5:0] A_THR = 6'h20, A_CNT = 6'h24, A_KEY = 6'h30;

  logic clk = 1'b0, rst_ni = 1'b0, req = 1'b0, we = 1'b0, dbg_halt = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        sys_rst;
  int errors = 0, checks = 0;
  bit done = 0;
  bit m_attn, m_priv, m_run, m_lock;
  logic [31:0] m_ctrl;

  always #2.5 clk = ~clk;

  wdt_top dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .dbg_halt_i(dbg_halt), .sys_rst_o(sys_rst)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rdchk(input logic [5:0] a, input logic [31:0] exp, input string rq);
    addr = a;
    #0.2;
    chk(rq, rdata, exp);
  endtask

  task automatic cmd(input logic [7:0] k);
    wr(A_KEY, 32'hA5);
    wr(A_KEY, {24'h0, k});
  endtask

  function automatic logic [31:0] st(bit a, bit p, bit r, bit l);
    return {28'h0, l, r, p, a};
  endfunction

  task automatic model_key(input logic [7:0] v);
    if (v == 8'hA5) m_attn = 1;
    else begin
      if (m_attn) begin
        case (v)
          8'hF1: if (!m_lock) m_priv = 1;
          8'hDD: if (!m_lock) m_run = 0;
          8'hEE: m_run = 1;
          8'hFF: begin m_lock = 1; m_priv = 0; end
          default: ;
        endcase
      end
      m_attn = 0;
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; req = 1'b0; we = 1'b0; dbg_halt = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    m_attn = 0; m_priv = 0; m_run = 0; m_lock = 0; m_ctrl = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] c1;
    do_reset();
    // R1 reset state
    rdchk(A_CTRL, 0, "R1 ctrl");
    rdchk(A_STAT, 0, "R1 status");
    rdchk(A_CNT, 0, "R1 count");
    rdchk(A_THR, 32'd1000, "R1 threshold");
    chk("R1 sys_rst", {31'h0, sys_rst}, 0);
    rdchk(A_KEY, 0, "R13 key reads zero");
    rdchk(6'h3C, 0, "R13 unmapped");

    // R2 / R3 key sequencing
    wr(A_KEY, 32'hEE);
    rdchk(A_STAT, st(0,0,0,0), "R3 start without attention");
    wr(A_KEY, 32'hA5);
    rdchk(A_STAT, st(1,0,0,0), "R2 attention accepted");
    wr(A_KEY, 32'hA5);
    rdchk(A_STAT, st(1,0,0,0), "R2 repeated attention");
    wr(A_KEY, 32'h12);
    rdchk(A_STAT, st(0,0,0,0), "R3 bad key clears attention");

    // R8 / R9 privilege and aliases
    wr(A_CTRL, 32'h2);
    rdchk(A_CTRL, 0, "R8 ctrl write without privilege");
    cmd(8'hF1);
    rdchk(A_STAT, st(0,1,0,0), "R8 privilege granted");
    wr(A_THR, 32'd20);
    rdchk(A_THR, 32'd20, "R8 threshold write");
    rdchk(A_STAT, st(0,0,0,0), "R8 privilege consumed");
    wr(A_CSET, 32'h2);
    rdchk(A_CTRL, 0, "R8 second write ignored");
    cmd(8'hF1); wr(A_CSET, 32'h2);
    rdchk(A_CTRL, 32'h2, "R9 set alias");
    cmd(8'hF1); wr(A_CCLR, 32'h2);
    rdchk(A_CTRL, 0, "R9 clear alias");
    cmd(8'hF1); wr(A_CTRL, 32'hFFFF_FFFF);
    rdchk(A_CTRL, 32'h2, "R9 direct alias masked");

    // R12 status aliases
    cmd(8'hF1);
    wr(A_SSET, 32'h1);
    rdchk(A_STAT, st(0,1,0,0), "R12 set alias ignored");
    wr(A_STAT, 32'h0);
    rdchk(A_STAT, st(0,1,0,0), "R12 direct alias ignored");
    wr(A_SCLR, 32'h2);
    rdchk(A_STAT, st(0,0,0,0), "R12 clear privilege");
    wr(A_KEY, 32'hA5);
    wr(A_SCLR, 32'h1);
    rdchk(A_STAT, st(0,0,0,0), "R12 clear attention");
    wr(A_KEY, 32'hF1);
    rdchk(A_STAT, st(0,0,0,0), "R3 permit after cleared attention");

    // R4 start and counting
    cmd(8'hEE);
    rdchk(A_CNT, 0, "R4 count after start");
    rdchk(A_STAT, st(0,0,1,0), "R4 running");
    wait_cyc(7);
    rdchk(A_CNT, 7, "R4 counting");
    // R10 freeze under debug halt
    dbg_halt = 1'b1;
    wait_cyc(4);
    rdchk(A_CNT, 7, "R10 frozen");
    dbg_halt = 1'b0;
    wait_cyc(3);
    rdchk(A_CNT, 10, "R10 resumed");
    // R5 reload
    cmd(8'hCC);
    rdchk(A_CNT, 0, "R5 reload");
    // R4 stop
    cmd(8'hDD);
    rdchk(A_STAT, st(0,0,0,0), "R4 stopped");
    addr = A_CNT; #0.2; c1 = rdata;
    wait_cyc(5);
    rdchk(A_CNT, c1, "R4 count holds when stopped");

    // R6 expiry at threshold 20
    cmd(8'hEE);
    wait_cyc(20);
    rdchk(A_CNT, 20, "R6 count at threshold");
    chk("R6 no reset yet", {31'h0, sys_rst}, 0);
    wait_cyc(1);
    chk("R6 reset raised", {31'h0, sys_rst}, 1);
    rdchk(A_CNT, 0, "R6 count wraps");
    wait_cyc(RSTC - 1);
    chk("R6 reset still high", {31'h0, sys_rst}, 1);
    wait_cyc(1);
    chk("R6 reset pulse length", {31'h0, sys_rst}, 0);
    cmd(8'hDD);

    // R7 reload on the expiry edge
    cmd(8'hEE);
    wait_cyc(17);
    cmd(8'hCC);
    chk("R7 no reset on collision", {31'h0, sys_rst}, 0);
    rdchk(A_CNT, 0, "R7 count reloaded");
    wait_cyc(1);
    chk("R7 still no reset", {31'h0, sys_rst}, 0);
    rdchk(A_CNT, 1, "R7 counting on");

    // R11 lock
    cmd(8'hFF);
    rdchk(A_STAT, st(0,0,1,1), "R11 locked");
    cmd(8'hDD);
    rdchk(A_STAT, st(0,0,1,1), "R11 disable ignored");
    cmd(8'hF1);
    rdchk(A_STAT, st(0,0,1,1), "R11 permit ignored");
    cmd(8'hCC);
    rdchk(A_CNT, 0, "R11 reload still works");
    do_reset();
    rdchk(A_STAT, 0, "R11 lock cleared by reset");

    // randomized phase against the bench model
    void'($urandom(32'd1234));
    for (int i = 0; i < 300; i++) begin
      int op;
      logic [31:0] d;
      op = int'($urandom % 4);
      if (op <= 1) begin
        case ($urandom % 8)
          0, 1: d = 32'hA5;
          2: d = 32'hF1;
          3: d = 32'hCC;
          4: d = 32'hDD;
          5: d = 32'hEE;
          6: d = (($urandom % 16) == 0) ? 32'hFF : 32'hA5;
          default: d = {24'h0, 8'($urandom)};
        endcase
        wr(A_KEY, d);
        model_key(d[7:0]);
      end else if (op == 2) begin
        logic [5:0] a;
        d = $urandom;
        case ($urandom % 3)
          0: a = A_CTRL;
          1: a = A_CSET;
          default: a = A_CCLR;
        endcase
        wr(a, d);
        if (m_priv) begin
          if (a == A_CTRL) m_ctrl = d & 32'h2;
          else if (a == A_CSET) m_ctrl = m_ctrl | (d & 32'h2);
          else m_ctrl = m_ctrl & ~(d & 32'h2);
          m_priv = 0;
        end
      end else begin
        d = {28'h0, 4'($urandom)};
        wr(A_SCLR, d);
        if (d[0]) m_attn = 0;
        if (d[1]) m_priv = 0;
      end
      rdchk(A_STAT, st(m_attn, m_priv, m_run, m_lock), "R2/R3/R8/R11/R12 random status");
      rdchk(A_CTRL, m_ctrl, "R8/R9 random ctrl");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule